// File: doc/BRIEF.md
# LVDT Excitation Generator and Coherent Demodulator

This block drives a linear variable differential transformer and turns its return signal back into a signed position word. A phase accumulator advances by a programmable step on every converter sample strobe. Its top bits address a quarter-wave sine table, and the resulting two's-complement code goes out to the excitation DAC. Full scale is used, and a step that gives a carrier near 5 kHz at the system sample rate is the intended setting.

The sensor returns a sine whose amplitude follows core displacement. Its phase is either aligned with the excitation or inverted, depending on which side of null the core sits. The block multiplies each ADC sample by a reference sine taken at the accumulator phase plus a programmable offset, which makes up for lag in the sensor and front end. The product carries the signed position as its mean value plus a ripple at twice the carrier frequency. A first-order recursive low-pass removes that ripple. The coherent product is what keeps the sign: an envelope detector would lose it.

A valid flag rises once the filter has run for a fixed number of whole carrier periods after reset. Scaling to physical units is left to the consumer.

Top module: `lvdt_demod`

## Requirements
- R1: While reset is low and on its release, `dac_o` is 0, `pos_o` is 0 and `pos_vld_o` is 0. The phase accumulator, the product register and the filter state are all cleared.
- R2: Each cycle with `smp_en_i` high adds `step_i` to a PHASE_W-bit accumulator, wrapping modulo 2^PHASE_W. After that cycle, `dac_o` equals round(32767·sin(2π·m/64)) as a signed two's-complement code, where m is the accumulator's top 6 bits.
- R3: While `smp_en_i` is low, `dac_o`, `pos_o` and `pos_vld_o` do not change, whatever `adc_i` carries.
- R4: With `ref_ofs_i` = 0 and a return in phase with the excitation at amplitude A, `pos_o` settles near +A/2. With the return inverted by 180°, it settles near −A/2.
- R5: On each strobe, the product register takes `adc_i` × ref, where ref is the table sine at phase (accumulator + `ref_ofs_i`), with the accumulator value taken before the update. On the same strobe, the filter takes y ← y + ((p − y) >>> FILT_SHIFT), where p is the previous product. `pos_o` equals y >>> 15.
- R6: With a return lagging the excitation by a quarter period, `ref_ofs_i` = 3·2^(PHASE_W−2) brings `pos_o` to about +A/2. With `ref_ofs_i` = 0, `pos_o` stays near 0.
- R7: `pos_vld_o` rises on the strobe that completes the SETTLE_CYC-th accumulator wrap after reset, and it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en_i | input | 1 | Converter sample strobe, one cycle per sample |
| step_i | input | PHASE_W | Phase increment per sample (sets carrier frequency) |
| ref_ofs_i | input | PHASE_W | Reference phase offset for lag compensation |
| adc_i | input | DATA_W | Signed sensor return sample |
| dac_o | output | 16 | Signed excitation code |
| pos_o | output | DATA_W+1 | Signed filtered position |
| pos_vld_o | output | 1 | Filter settled |

## Verification
The assertions assume that `adc_i` is a signed two's-complement sample. They also assume that `smp_en_i` is the only event that advances the datapath, so all state is expected to hold between strobes. The bench builds each return sample from the model's phase as a scaled sine with small noise and clips it to the 16-bit range. It places idle cycles of random length between strobes, so the hold behaviour is exercised throughout the run. `step_i` and `ref_ofs_i` change only between strobes.

// File: rtl/lvdt_pkg.sv
package lvdt_pkg;
    localparam int SINE_W   = 16;
    localparam int LUT_IDX  = 6;
    localparam int QTR_BITS = LUT_IDX - 2;

    // quarter-wave magnitude, k = 0 .. 2**QTR_BITS
    function automatic logic [SINE_W-1:0] qtr_mag(input logic [QTR_BITS:0] k);
        case (k)
            5'd0:    return 16'd0;
            5'd1:    return 16'd3212;
            5'd2:    return 16'd6393;
            5'd3:    return 16'd9512;
            5'd4:    return 16'd12539;
            5'd5:    return 16'd15446;
            5'd6:    return 16'd18204;
            5'd7:    return 16'd20787;
            5'd8:    return 16'd23170;
            5'd9:    return 16'd25329;
            5'd10:   return 16'd27245;
            5'd11:   return 16'd28898;
            5'd12:   return 16'd30273;
            5'd13:   return 16'd31356;
            5'd14:   return 16'd32137;
            5'd15:   return 16'd32609;
            default: return 16'd32767;
        endcase
    endfunction
endpackage

// File: rtl/lvdt_sine_lut.sv
module lvdt_sine_lut
    import lvdt_pkg::*;
(
    input  logic [LUT_IDX-1:0]       idx_i,
    output logic signed [SINE_W-1:0] sin_o
);
    logic [1:0]          quad;
    logic [QTR_BITS:0]   k;
    logic [SINE_W-1:0]   mag;

    always_comb begin
        quad = idx_i[LUT_IDX-1 -: 2];
        k    = quad[0] ? ((QTR_BITS+1)'(1 << QTR_BITS) - {1'b0, idx_i[QTR_BITS-1:0]})
                       : {1'b0, idx_i[QTR_BITS-1:0]};
        mag  = qtr_mag(k);
        sin_o = quad[1] ? -$signed(mag) : $signed(mag);
    end
endmodule

// File: rtl/lvdt_nco.sv
module lvdt_nco
    import lvdt_pkg::*;
#(
    parameter int PHASE_W = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_en_i,
    input  logic [PHASE_W-1:0]        step_i,
    input  logic [PHASE_W-1:0]        ref_ofs_i,
    output logic signed [SINE_W-1:0]  dac_o,
    output logic signed [SINE_W-1:0]  ref_o,
    output logic                      wrap_o
);
    typedef struct packed {
        logic [PHASE_W-1:0]        phase;
        logic signed [SINE_W-1:0]  dac;
    } nco_st_t;

    nco_st_t st_d, st_q;
    logic [PHASE_W:0]          sum;
    logic [PHASE_W-1:0]        ref_ph;
    logic [PHASE_W-1:0]        lut_ph  [2];
    logic signed [SINE_W-1:0]  lut_val [2];

    assign lut_ph[0] = st_d.phase;
    assign lut_ph[1] = ref_ph;

    for (genvar g = 0; g < 2; g++) begin : g_lut
        lvdt_sine_lut u_lut (
            .idx_i (lut_ph[g][PHASE_W-1 -: LUT_IDX]),
            .sin_o (lut_val[g])
        );
    end

    always_comb begin
        st_d   = st_q;
        sum    = {1'b0, st_q.phase} + {1'b0, step_i};
        ref_ph = st_q.phase + ref_ofs_i;
        wrap_o = smp_en_i & sum[PHASE_W];
        if (smp_en_i) st_d.phase = sum[PHASE_W-1:0];
        st_d.dac = lut_val[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dac_o = st_q.dac;
    assign ref_o = lut_val[1];

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en_i |=> $stable(st_q.phase) && $stable(dac_o));
    // R2
    dac_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_o != -16'sd32768);
endmodule

// File: rtl/lvdt_mix_lpf.sv
module lvdt_mix_lpf
    import lvdt_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FILT_SHIFT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_en_i,
    input  logic signed [DATA_W-1:0]  adc_i,
    input  logic signed [SINE_W-1:0]  ref_i,
    output logic signed [DATA_W:0]    pos_o
);
    localparam int PROD_W = DATA_W + SINE_W;

    typedef struct packed {
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] acc;
    } lpf_st_t;

    lpf_st_t st_d, st_q;
    logic signed [PROD_W:0]   diff;
    logic signed [PROD_W:0]   delta;
    logic signed [PROD_W:0]   sum;
    logic signed [PROD_W-1:0] shifted;

    always_comb begin
        st_d  = st_q;
        diff  = {st_q.prod[PROD_W-1], st_q.prod} - {st_q.acc[PROD_W-1], st_q.acc};
        delta = diff >>> FILT_SHIFT;
        sum   = {st_q.acc[PROD_W-1], st_q.acc} + delta;
        if (smp_en_i) begin
            st_d.prod = PROD_W'(adc_i) * PROD_W'(ref_i);
            st_d.acc  = sum[PROD_W-1:0];
        end
        shifted = st_q.acc >>> (SINE_W - 1);
        pos_o   = shifted[DATA_W:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en_i |=> $stable(st_q.acc) && $stable(st_q.prod));
    // R5
    acc_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en_i && ($past(st_q.prod) >= $past(st_q.acc)) |=>
        (st_q.acc >= $past(st_q.acc)) && (st_q.acc <= $past(st_q.prod)));
endmodule

// File: rtl/lvdt_settle.sv
module lvdt_settle #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    output logic vld_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             vld;
    } set_st_t;

    set_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wrap_i && !st_q.vld) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == CNT_W'(SETTLE_CYC)) st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;

    // R7
    vld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> vld_o);
    // R7
    vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o && !wrap_i |=> !vld_o);
endmodule

// File: rtl/lvdt_demod.sv
module lvdt_demod
    import lvdt_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int PHASE_W    = 24,
    parameter int FILT_SHIFT = 4,
    parameter int SETTLE_CYC = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_en_i,
    input  logic [PHASE_W-1:0]        step_i,
    input  logic [PHASE_W-1:0]        ref_ofs_i,
    input  logic signed [DATA_W-1:0]  adc_i,
    output logic signed [SINE_W-1:0]  dac_o,
    output logic signed [DATA_W:0]    pos_o,
    output logic                      pos_vld_o
);
    logic signed [SINE_W-1:0] ref_s;
    logic                     wrap_s;

    lvdt_nco #(.PHASE_W(PHASE_W)) u_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_en_i  (smp_en_i),
        .step_i    (step_i),
        .ref_ofs_i (ref_ofs_i),
        .dac_o     (dac_o),
        .ref_o     (ref_s),
        .wrap_o    (wrap_s)
    );

    lvdt_mix_lpf #(.DATA_W(DATA_W), .FILT_SHIFT(FILT_SHIFT)) u_lpf (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en_i (smp_en_i),
        .adc_i    (adc_i),
        .ref_i    (ref_s),
        .pos_o    (pos_o)
    );

    lvdt_settle #(.SETTLE_CYC(SETTLE_CYC)) u_set (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap_i (wrap_s),
        .vld_o  (pos_vld_o)
    );

    // R1
    rst_out_chk: assert property (@(posedge clk)
        !rst_n |=> dac_o == 0 && pos_o == 0 && !pos_vld_o);
endmodule

// File: tb/tb_lvdt_demod.sv
module tb_lvdt_demod;
    localparam int PW = 24;
    localparam real PI = 3.14159265358979;

    logic clk = 0, rst_n = 0, smp_en = 0;
    logic [PW-1:0] step = 0, ofs = 0;
    logic signed [15:0] adc = 0;
    logic signed [15:0] dac;
    logic signed [16:0] pos;
    logic vld;

    int checks = 0, errors = 0;
    bit done = 0;

    longint ph_m, p_m, y_m;
    int wraps_m;

    lvdt_demod dut (
        .clk(clk), .rst_n(rst_n), .smp_en_i(smp_en), .step_i(step),
        .ref_ofs_i(ofs), .adc_i(adc), .dac_o(dac), .pos_o(pos), .pos_vld_o(vld)
    );

    always #2ns clk = ~clk;

    function automatic int rnd(input real r);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    function automatic int sinv(input longint ph);
        longint m = (ph >> (PW - 6)) & 63;
        return rnd(32767.0 * $sin(2.0 * PI * real'(m) / 64.0));
    endfunction

    task automatic chk(input string req, input longint act, input longint exp, input longint tol);
        checks++;
        if (act > exp + tol || act < exp - tol) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        ph_m = 0; p_m = 0; y_m = 0; wraps_m = 0;
    endtask

    // one strobe; amplitude amp, extra phase shift sh (radians), idle gap afterwards
    task automatic strobe(input int amp, input real sh, input int gap, input bit verify);
        real th;
        int a, r;
        th = 2.0 * PI * real'(ph_m) / real'(64'd1 << PW) + sh;
        a = rnd(real'(amp) * $sin(th)) + int'($urandom % 33) - 16;
        if (a > 32767) a = 32767;
        if (a < -32767) a = -32767;
        @(negedge clk);
        smp_en = 1; adc = 16'(a);
        @(negedge clk);
        smp_en = 0;
        adc = 16'($urandom);
        r = sinv((ph_m + longint'(ofs)) & ((64'd1 << PW) - 1));
        y_m = y_m + ((p_m - y_m) >>> 4);
        p_m = longint'(a) * longint'(r);
        ph_m = ph_m + longint'(step);
        if (ph_m >= (64'd1 << PW)) begin
            ph_m = ph_m - (64'd1 << PW);
            wraps_m++;
        end
        if (verify) begin
            chk("R2 dac", dac, sinv(ph_m), 1);
            chk("R5 pos", pos, y_m >>> 15, 2);
            chk("R7 vld", vld, (wraps_m >= 8) ? 1 : 0, 0);
        end
        repeat (gap) @(negedge clk);
    endtask

    task automatic run(input int n, input int amp, input real sh);
        for (int i = 0; i < n; i++) strobe(amp, sh, int'($urandom % 3), 1'b1);
    endtask

    initial begin
        logic signed [15:0] d0;
        logic signed [16:0] p0;
        logic v0;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 dac", dac, 0, 0);
        chk("R1 pos", pos, 0, 0);
        chk("R1 vld", vld, 0, 0);
        rst_n = 1;
        step = 24'h100000;

        // R7 exact settle point: wrap 8 completes on strobe 128
        for (int i = 0; i < 127; i++) strobe(20000, 0.0, int'($urandom % 3), 1'b1);
        chk("R7 before settle", vld, 0, 0);
        strobe(20000, 0.0, 0, 1'b1);
        chk("R7 settle edge", vld, 1, 0);

        // R4 in-phase
        run(120, 20000, 0.0);
        chk("R4 in-phase level", pos, 10000, 1300);

        // R3 hold with adc toggling
        d0 = dac; p0 = pos; v0 = vld;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            adc = 16'($urandom);
        end
        chk("R3 dac hold", dac, d0, 0);
        chk("R3 pos hold", pos, p0, 0);
        chk("R3 vld hold", vld, v0, 0);

        // R4 inverted
        run(200, 12000, PI);
        chk("R4 inverted level", pos, -6000, 1300);

        // R6 quarter lag uncompensated then compensated
        run(200, 16000, -PI / 2.0);
        chk("R6 lag no offset", pos, 0, 1300);
        ofs = 24'hC00000;
        run(200, 16000, -PI / 2.0);
        chk("R6 lag compensated", pos, 8000, 1300);

        // R2 other frequency, R7 sticky
        ofs = 0;
        step = 24'h080000;
        run(160, 24000, 0.0);
        chk("R4 slower carrier", pos, 12000, 1000);
        chk("R7 sticky", vld, 1, 0);

        // R1 mid-run reset
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk);
        chk("R1 rerst dac", dac, 0, 0);
        chk("R1 rerst pos", pos, 0, 0);
        chk("R1 rerst vld", vld, 0, 0);
        rst_n = 1;
        model_reset();
        step = 24'h123457;
        run(40, 30000, 0.3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule